// File: doc/BRIEF.md
# Burst ROM Read Controller

This block is a master on an external memory bus, built to fetch from ROM parts that serve consecutive locations quickly. An internal requester hands it one transfer at a time: a read, a 32-byte line fill, or a write. With each transfer come the bus width, a burst-length code, a wait-state count and optional address setup and hold counts. The block then drives the address, an active-low chip select, an active-low read strobe and an active-low write strobe. It also samples an active-high ready input coming back from the memory.

A burst read opens like an ordinary static-memory read. After the first beat is captured, chip select and the read strobe stay low, and only the address moves to the next location. Each captured beat is returned on a valid-only stream. A line fill starts at the requested word and walks through the rest of its aligned 32-byte block. Writes always run as one static-memory style access.

Flow rules: the request side is a valid/ready handshake. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The return stream has no back-pressure. `rd_valid` is high for one cycle per beat, and the requester must take `rd_data` in that cycle. The configuration inputs and the request fields are captured only when the request is taken.

Top module: `brom_bus_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1; `bus_cs_n`, `bus_rd_n` and `bus_we_n` are 1; `rd_valid` and `done` are 0.
- R2: With `cfg_burst` = 0, a read that is not a line fill is one beat. The read strobe is low for 1 + `cfg_wait` cycles, and one `rd_valid` pulse is produced.
- R3: A non-zero `cfg_burst` selects the burst length for a read: code 1 gives 4 beats, 2 gives 8, 3 gives 16 and 4 gives 32. The legal lengths are up to 32 beats for an 8-bit bus, up to 16 for 16-bit and up to 8 for 32-bit. `cfg_width` 0 selects an 8-bit bus, 1 selects 16-bit, and 2 or 3 select 32-bit.
- R4: A burst code larger than the width allows falls back to the longest legal length for that width.
- R5: The start address has the bits below the bus width cleared. Each later beat adds the bus width in bytes and wraps inside the aligned block of (beats × bytes) bytes. Only lane bytes of the width are returned; the upper bytes of `rd_data` read 0.
- R6: From acceptance to `done`, chip select stays low without a gap. The read strobe stays low from the first strobe cycle until the last beat is captured.
- R7: In burst mode, every beat after the first takes max(`cfg_wait`, 1) + 1 cycles, so a zero-wait burst still spends two cycles on each later beat.
- R8: When `cfg_wait` > 0, `bus_rdy` is sampled in the last wait cycle of each beat, and the beat is extended while it is 0. When `cfg_wait` = 0, `bus_rdy` has no effect.
- R9: A line fill (`req_line` = 1) runs 32 / bytes beats whatever `cfg_burst` is. It starts at the requested word and wraps inside the aligned 32-byte block. With `cfg_burst` = 0, its later beats take `cfg_wait` + 1 cycles.
- R10: `cfg_setup` cycles with only chip select low come before the first strobe. `cfg_hold` cycles with only chip select low come after the last beat, before `done`.
- R11: A write is always a single beat. The write strobe is low for 1 + `cfg_wait` cycles, with the aligned address and the captured write data. The read strobe stays high and there is no `rd_valid`, even when a burst code is set.
- R12: `done` pulses once for one cycle when a transfer finishes, and `req_ready` is high in that cycle. A request that is held pending during a transfer is taken on the edge right after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_line | input | 1 | 1 = 32-byte line fill (reads only) |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write data |
| cfg_width | input | 2 | Bus width code |
| cfg_burst | input | 3 | Burst-length code, 0 = static-memory reads |
| cfg_wait | input | WAIT_W | Wait states per beat |
| cfg_setup | input | SH_W | Address setup cycles |
| cfg_hold | input | SH_W | Address hold cycles |
| rd_valid | output | 1 | One pulse per captured read beat |
| rd_data | output | DATA_W | Beat data, zero above the bus width |
| done | output | 1 | Transfer finished pulse |
| bus_addr | output | ADDR_W | External byte address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_wdata | output | DATA_W | External write data |
| bus_rdata | input | DATA_W | External read data |
| bus_rdy | input | 1 | Memory ready, active high |

## Verification
The memory model returns a word derived from the address, so every beat's data shows which address was on the bus and whether the wrap was correct.

Bursts start at unaligned, mid-block addresses for all three widths. This tells a correct wrap apart from a linear run or a wrap over the wrong block size. Illegal burst codes separate fallback from truncation of the code.

Beat timing is measured in cycles for zero and non-zero wait counts, with and without a ready stall, and with ready held low while no waits are set. These runs separate the two-cycle minimum in burst mode, ready sampling, and ready being ignored. Setup/hold runs and a write issued with a burst code set check strobe shaping. A request held pending during a transfer checks the idle-only handshake.

// File: rtl/brom_pkg.sv
package brom_pkg;
  localparam int LINE_BYTES = 32;
  localparam int LOG_LINE   = $clog2(LINE_BYTES);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_HOLD   = 2'd3
  } brom_state_e;
endpackage

// File: rtl/brom_beat_plan.sv
// Works out beat count, lane size and wrap mask for one transfer.
module brom_beat_plan
  import brom_pkg::*;
(
  input  logic [1:0]          width_i,
  input  logic [2:0]          burst_i,
  input  logic                line_i,
  output logic [1:0]          lgb_o,
  output logic [LOG_LINE:0]   beats_o,
  output logic [LOG_LINE-1:0] wrap_mask_o
);
  int lgb;
  int max_code;
  int code;
  int lg_beats;

  always_comb begin
    lgb      = (width_i == 2'd3) ? 2 : int'(width_i);
    // longest legal burst keeps beats*bytes within one line
    max_code = LOG_LINE - 1 - lgb;
    code     = (int'(burst_i) > max_code) ? max_code : int'(burst_i);
    if (line_i)          lg_beats = LOG_LINE - lgb;
    else if (code == 0)  lg_beats = 0;
    else                 lg_beats = code + 1;
    lgb_o       = 2'(lgb);
    beats_o     = (LOG_LINE+1)'(1 << lg_beats);
    wrap_mask_o = LOG_LINE'((1 << (lg_beats + lgb)) - 1);
  end
endmodule

// File: rtl/brom_addr_step.sv
// Next beat address: step by lane size, wrap inside the masked block.
module brom_addr_step #(
  parameter int ADDR_W = 24,
  parameter int MASK_W = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        lgb_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] m;
  logic [ADDR_W-1:0] inc;

  always_comb begin
    m      = ADDR_W'(mask_i);
    inc    = addr_i + (ADDR_W'(1) << lgb_i);
    next_o = (addr_i & ~m) | (inc & m);
  end
endmodule

// File: rtl/brom_bus_ctrl.sv
module brom_bus_ctrl
  import brom_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4,
  parameter int SH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_line,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        cfg_width,
  input  logic [2:0]        cfg_burst,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [SH_W-1:0]   cfg_setup,
  input  logic [SH_W-1:0]   cfg_hold,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_we_n,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rdy
);
  localparam int CNT_W = (WAIT_W > SH_W) ? WAIT_W : SH_W;
  localparam int LANES = DATA_W / 8;

  brom_state_e         state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [LOG_LINE:0]   left_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                write_q;
  logic                chk_rdy_q;
  logic [CNT_W-1:0]    later_q;
  logic [SH_W-1:0]     hold_q;
  logic [1:0]          lgb_q;
  logic [LOG_LINE-1:0] mask_q;
  logic                rd_valid_q;
  logic [DATA_W-1:0]   rd_data_q;
  logic                done_q;

  // transfer plan from the request currently offered
  logic [1:0]          plan_lgb;
  logic [LOG_LINE:0]   plan_beats;
  logic [LOG_LINE-1:0] plan_mask;
  logic [2:0]          eff_burst;
  logic                eff_line;

  assign eff_burst = req_write ? 3'd0 : cfg_burst;
  assign eff_line  = req_line & ~req_write;

  brom_beat_plan u_plan (
    .width_i     (cfg_width),
    .burst_i     (eff_burst),
    .line_i      (eff_line),
    .lgb_o       (plan_lgb),
    .beats_o     (plan_beats),
    .wrap_mask_o (plan_mask)
  );

  logic [ADDR_W-1:0] next_addr;
  brom_addr_step #(.ADDR_W(ADDR_W), .MASK_W(LOG_LINE)) u_step (
    .addr_i (addr_q),
    .lgb_i  (lgb_q),
    .mask_i (plan_mask_q_sel),
    .next_o (next_addr)
  );

  logic [LOG_LINE-1:0] plan_mask_q_sel;
  assign plan_mask_q_sel = mask_q;

  // aligned start address and per-beat wait for later beats
  logic [ADDR_W-1:0] start_addr;
  logic [CNT_W-1:0]  later_wait;
  logic              burst_mode;

  always_comb begin
    start_addr = req_addr & ~ADDR_W'((32'd1 << plan_lgb) - 32'd1);
    burst_mode = (cfg_burst != 3'd0) && !req_write;
    later_wait = (burst_mode && cfg_wait == '0) ? CNT_W'(1) : CNT_W'(cfg_wait);
  end

  // keep only the byte lanes that the bus width uses
  logic [DATA_W-1:0] lane_data;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_data[g*8 +: 8] =
      (32'(g) < (32'd1 << lgb_q)) ? bus_rdata[g*8 +: 8] : 8'h00;
  end

  logic accept;
  logic beat_end;
  assign accept   = req_valid && (state_q == ST_IDLE);
  assign beat_end = (state_q == ST_ACCESS) && (cnt_q == '0) &&
                    (!chk_rdy_q || bus_rdy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      left_q     <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      write_q    <= 1'b0;
      chk_rdy_q  <= 1'b0;
      later_q    <= '0;
      hold_q     <= '0;
      lgb_q      <= '0;
      mask_q     <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      done_q     <= 1'b0;
    end else begin
      rd_valid_q <= 1'b0;
      done_q     <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q    <= start_addr;
            wdata_q   <= req_wdata;
            write_q   <= req_write;
            chk_rdy_q <= (cfg_wait != '0);
            later_q   <= later_wait;
            hold_q    <= cfg_hold;
            lgb_q     <= plan_lgb;
            mask_q    <= plan_mask;
            left_q    <= plan_beats;
            if (cfg_setup != '0) begin
              state_q <= ST_SETUP;
              cnt_q   <= CNT_W'(cfg_setup) - CNT_W'(1);
            end else begin
              state_q <= ST_ACCESS;
              cnt_q   <= CNT_W'(cfg_wait);
            end
          end
        end
        ST_SETUP: begin
          if (cnt_q == '0) begin
            state_q <= ST_ACCESS;
            cnt_q   <= CNT_W'(cfg_wait_q_sel);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_ACCESS: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (beat_end) begin
            if (!write_q) begin
              rd_valid_q <= 1'b1;
              rd_data_q  <= lane_data;
            end
            if (left_q == (LOG_LINE+1)'(1)) begin
              if (hold_q != '0) begin
                state_q <= ST_HOLD;
                cnt_q   <= CNT_W'(hold_q) - CNT_W'(1);
              end else begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            end else begin
              left_q <= left_q - (LOG_LINE+1)'(1);
              addr_q <= next_addr;
              cnt_q  <= later_q;
            end
          end
        end
        ST_HOLD: begin
          if (cnt_q == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // first-beat wait captured at acceptance, used when setup ends
  logic [WAIT_W-1:0] wait_q;
  logic [WAIT_W-1:0] cfg_wait_q_sel;
  assign cfg_wait_q_sel = wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wait_q <= '0;
    else if (accept) wait_q <= cfg_wait;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign bus_cs_n  = (state_q == ST_IDLE);
  assign bus_rd_n  = !((state_q == ST_ACCESS) && !write_q);
  assign bus_we_n  = !((state_q == ST_ACCESS) && write_q);
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;
  assign done      = done_q;
endmodule

// File: rtl/brom_bus_ctrl_chk.sv
module brom_bus_ctrl_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_cs_n,
  input logic              bus_rd_n,
  input logic              bus_we_n
);
  // R11: read and write strobes never overlap
  a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_we_n));

  // R6: any strobe lies inside chip select
  a_r6_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_we_n) |-> !bus_cs_n);

  // R12: idle means the bus is released
  a_r12_ready_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cs_n && bus_rd_n && bus_we_n));

  // R12: done appears together with readiness
  a_r12_done_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R5: during a strobe the address only moves right after a captured beat
  a_r5_addr_moves_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n && !$past(bus_rd_n) && (bus_addr != $past(bus_addr))) |-> rd_valid);

  // R11: a write cycle never yields read data
  a_r11_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_we_n) |-> !rd_valid);
endmodule

bind brom_bus_ctrl brom_bus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .done      (done),
  .bus_addr  (bus_addr),
  .bus_cs_n  (bus_cs_n),
  .bus_rd_n  (bus_rd_n),
  .bus_we_n  (bus_we_n)
);

// File: tb/brom_bus_ctrl_tb_top.sv
module brom_bus_ctrl_tb_top;
  localparam int AW = 24;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic          req_line = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    cfg_width = 2'd2;
  logic [2:0]    cfg_burst = 3'd0;
  logic [3:0]    cfg_wait = 4'd0;
  logic [1:0]    cfg_setup = 2'd0;
  logic [1:0]    cfg_hold = 2'd0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          done;
  logic [AW-1:0] bus_addr;
  logic          bus_cs_n, bus_rd_n, bus_we_n;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          bus_rdy;

  brom_bus_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_line(req_line), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_width(cfg_width), .cfg_burst(cfg_burst), .cfg_wait(cfg_wait),
    .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_we_n(bus_we_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdy(bus_rdy)
  );

  // memory model: data encodes the address
  function automatic logic [31:0] rom_word(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h3C, a[7:0] + 8'h11, ~a[7:0], a[7:0]};
  endfunction
  assign bus_rdata = rom_word(bus_addr);

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ready generation
  int stall_left = 0;
  bit force_low = 1'b0;
  logic rdy_stall = 1'b0;
  always @(negedge clk) begin
    if (stall_left > 0 && !bus_rd_n) begin
      rdy_stall = 1'b1;
      stall_left--;
    end else begin
      rdy_stall = 1'b0;
    end
  end
  assign bus_rdy = !(force_low || rdy_stall);

  // monitor
  bit            mon_on = 1'b0;
  logic [31:0]   beat_data [64];
  int            beat_cyc [64];
  int            nb = 0, ndone = 0, done_cyc = 0;
  int            cs_low = 0, rd_low = 0, we_low = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  int            acc_cyc [4];
  int            nacc = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (rd_valid && nb < 64) begin
        beat_data[nb] = rd_data;
        beat_cyc[nb]  = cyc;
        nb++;
      end
      if (done) begin
        done_cyc = cyc;
        ndone++;
      end
      if (!bus_cs_n) cs_low++;
      if (!bus_rd_n) rd_low++;
      if (!bus_we_n) begin
        we_low++;
        wr_addr = bus_addr;
        wr_data = bus_wdata;
      end
    end
  end

  always @(posedge clk) begin
    if (mon_on && req_valid && req_ready && nacc < 4) begin
      acc_cyc[nacc] = cyc + 1;
      nacc++;
    end
  end

  task automatic mon_clear();
    nb = 0; ndone = 0; done_cyc = 0;
    cs_low = 0; rd_low = 0; we_low = 0; nacc = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // issue one request, wait for done; returns acceptance cycle
  task automatic run_txn(input logic wr, input logic line, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, output int t0);
    mon_clear();
    mon_on = 1'b1;
    req_write = wr; req_line = line; req_addr = a; req_wdata = wd;
    req_valid = 1'b1;
    while (!req_ready) tick();
    t0 = cyc + 1;
    tick();
    req_valid = 1'b0;
    while (ndone == 0) tick();
    tick();
    mon_on = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] w, input logic [2:0] b,
                         input int wt, input int s, input int h);
    cfg_width = w; cfg_burst = b; cfg_wait = 4'(wt);
    cfg_setup = 2'(s); cfg_hold = 2'(h);
  endtask

  // full read check: beat count, data per address, timing, strobe shape
  task automatic run_read(input string req, input logic line, input logic [AW-1:0] a,
                          input int exp_beats, input int step, input int ext);
    int t0, bytes, span, bad_d, bad_t, first, last;
    logic [AW-1:0] cur;
    logic [31:0] msk, expd;
    run_txn(1'b0, line, a, '0, t0);
    bytes = (cfg_width == 2'd0) ? 1 : (cfg_width == 2'd1) ? 2 : 4;
    msk   = (bytes == 1) ? 32'hFF : (bytes == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
    span  = exp_beats * bytes;
    cur   = a & ~AW'(bytes - 1);
    first = t0 + int'(cfg_setup) + int'(cfg_wait) + 1 + ext;
    bad_d = 0; bad_t = 0;
    check(nb == exp_beats, req, "beat count", nb, exp_beats);
    for (int k = 0; k < nb && k < exp_beats; k++) begin
      expd = rom_word(cur) & msk;
      if (beat_data[k] !== expd) begin
        if (bad_d == 0) $display("FAIL %s beat %0d data: actual=%0h expected=%0h",
                                 req, k, beat_data[k], expd);
        bad_d++;
      end
      if (beat_cyc[k] != first + k * step) begin
        if (bad_t == 0) $display("FAIL %s beat %0d cycle: actual=%0d expected=%0d",
                                 req, k, beat_cyc[k] - t0, first + k * step - t0);
        bad_t++;
      end
      cur = (cur & ~AW'(span - 1)) | ((cur + AW'(bytes)) & AW'(span - 1));
    end
    checks += 2;
    if (bad_d != 0) failures++;
    if (bad_t != 0) failures++;
    last = first + (exp_beats - 1) * step;
    check(done_cyc == last + int'(cfg_hold), req, "done cycle",
          done_cyc - t0, last + int'(cfg_hold) - t0);
    check(ndone == 1, "R12", "single done pulse", ndone, 1);
    check(cs_low == done_cyc - t0, "R6", "chip select gap-free", cs_low, done_cyc - t0);
    check(rd_low == last - t0 - int'(cfg_setup), "R6", "read strobe continuous",
          rd_low, last - t0 - int'(cfg_setup));
    check(we_low == 0, "R11", "no write strobe on read", we_low, 0);
  endtask

  task automatic t_reset();
    check(req_ready === 1'b1, "R1", "req_ready", req_ready, 1);
    check({bus_cs_n, bus_rd_n, bus_we_n} === 3'b111, "R1", "strobes idle",
          {bus_cs_n, bus_rd_n, bus_we_n}, 3'b111);
    check({rd_valid, done} === 2'b00, "R1", "no pulses", {rd_valid, done}, 0);
  endtask

  task automatic t_sram_read();
    set_cfg(2'd2, 3'd0, 2, 0, 0);
    run_read("R2", 1'b0, 24'h000123, 1, 0, 0);
  endtask

  task automatic t_burst_lengths();
    set_cfg(2'd2, 3'd1, 0, 0, 0);
    run_read("R3", 1'b0, 24'h000018, 4, 2, 0);   // R5 wrap 0x18,0x1C,0x10,0x14
    set_cfg(2'd1, 3'd3, 0, 0, 0);
    run_read("R3", 1'b0, 24'h000107, 16, 2, 0);
    set_cfg(2'd0, 3'd4, 0, 0, 0);
    run_read("R5", 1'b0, 24'h000245, 32, 2, 0);
    set_cfg(2'd0, 3'd2, 0, 0, 0);
    run_read("R3", 1'b0, 24'h000036, 8, 2, 0);
  endtask

  task automatic t_fallback();
    set_cfg(2'd2, 3'd4, 0, 0, 0);
    run_read("R4", 1'b0, 24'h00030C, 8, 2, 0);
    set_cfg(2'd1, 3'd7, 0, 0, 0);
    run_read("R4", 1'b0, 24'h000412, 16, 2, 0);
    set_cfg(2'd3, 3'd3, 0, 0, 0);
    run_read("R4", 1'b0, 24'h000504, 8, 2, 0);
  endtask

  task automatic t_wait_beats();
    set_cfg(2'd1, 3'd2, 3, 0, 0);
    run_read("R7", 1'b0, 24'h00060A, 8, 4, 0);
  endtask

  task automatic t_ready();
    set_cfg(2'd2, 3'd1, 1, 0, 0);
    stall_left = 3;
    run_read("R8", 1'b0, 24'h000708, 4, 2, 2);
    stall_left = 0;
    set_cfg(2'd2, 3'd1, 0, 0, 0);
    force_low = 1'b1;
    run_read("R8", 1'b0, 24'h000804, 4, 2, 0);
    force_low = 1'b0;
  endtask

  task automatic t_line_fill();
    set_cfg(2'd0, 3'd2, 0, 0, 0);
    run_read("R9", 1'b1, 24'h00092D, 32, 2, 0);
    set_cfg(2'd2, 3'd0, 1, 0, 0);
    run_read("R9", 1'b1, 24'h000A44, 8, 2, 0);
    set_cfg(2'd1, 3'd0, 0, 0, 0);
    run_read("R9", 1'b1, 24'h000B1A, 16, 1, 0);
  endtask

  task automatic t_setup_hold();
    set_cfg(2'd2, 3'd1, 1, 2, 3);
    run_read("R10", 1'b0, 24'h000C10, 4, 2, 0);
  endtask

  task automatic t_write();
    int t0;
    set_cfg(2'd2, 3'd2, 2, 1, 1);
    run_txn(1'b1, 1'b1, 24'h000D31, 32'hCAFE_F00D, t0);
    check(nb == 0, "R11", "no read data on write", nb, 0);
    check(we_low == 3, "R11", "write strobe length", we_low, 3);
    check(rd_low == 0, "R11", "read strobe idle on write", rd_low, 0);
    check(wr_addr == 24'h000D30, "R11", "write address", wr_addr, 24'h000D30);
    check(wr_data == 32'hCAFE_F00D, "R11", "write data", wr_data, 32'hCAFE_F00D);
    check(done_cyc == t0 + 5, "R10", "write done with setup/hold", done_cyc - t0, 5);
  endtask

  task automatic t_pending();
    set_cfg(2'd2, 3'd1, 0, 0, 0);
    mon_clear();
    mon_on = 1'b1;
    req_write = 1'b0; req_line = 1'b0; req_addr = 24'h000E00;
    req_valid = 1'b1;
    while (nacc < 1) tick();
    while (ndone == 0) tick();
    check(ndone == 1, "R12", "first done", ndone, 1);
    while (nacc < 2) tick();
    req_valid = 1'b0;
    check(acc_cyc[1] == done_cyc + 1, "R12", "pending request taken after done",
          acc_cyc[1] - acc_cyc[0], done_cyc + 1 - acc_cyc[0]);
    while (ndone < 2) tick();
    tick();
    check(nb == 8, "R12", "beats of both bursts", nb, 8);
    mon_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_sram_read();
    t_burst_lengths();
    t_fallback();
    t_wait_beats();
    t_ready();
    t_line_fill();
    t_setup_hold();
    t_write();
    t_pending();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R12 watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule